// File: doc/BRIEF.md
# Fast-Path Block Download Sequencer

This block sits on the probe side of a debug link. It pushes a block of 32-bit words into a stalled target CPU through the one-bit fast transfer path. It does not drive the JTAG pins itself. It sends IR and DR scan requests to a generic scan engine and reads back the bits that each scan shifts out. A debug handler must already be running on the target. That handler loads words from a small window in the debug memory segment and stores them to target memory.

A run starts with a `start` pulse. The sequencer first reads the pending-address register and confirms that the CPU is stalled at the window base. It then loads the fast-transfer instruction into the IR once and sends one 33-bit scan per word. It does not poll before each scan. Instead it reads the status bit that the same scan returns. A status of 0 means no access was pending, so the same word is sent again until it succeeds or the retry budget runs out. Words come from a valid/pop source, and a word is popped only after the target has accepted it. At the end the sequencer reads the pending-address register again and checks that the CPU has returned to the debug vector.

The states, in order, are:

- `S_IDLE`: waits for `start`.
- `S_ENTRY_IR` and `S_ENTRY_DR`: the entry address check.
- `S_FAST_IR`: loads the fast-transfer instruction.
- `S_WAIT_WORD` and `S_SEND`: the word loop.
- `S_EXIT_IR` and `S_EXIT_DR`: the exit address check.
- `S_END`: the done cycle.

The transitions are:

| From | Condition | To |
|---|---|---|
| `S_IDLE` | start | `S_ENTRY_IR` |
| `S_ENTRY_IR` | ack | `S_ENTRY_DR` |
| `S_ENTRY_DR` | ack, bad address | `S_END` |
| `S_ENTRY_DR` | ack, count 0 | `S_EXIT_IR` |
| `S_ENTRY_DR` | ack, otherwise | `S_FAST_IR` |
| `S_FAST_IR` | ack | `S_WAIT_WORD` |
| `S_WAIT_WORD` | `src_valid` | `S_SEND` |
| `S_SEND` | status 1 | `S_WAIT_WORD`, or `S_EXIT_IR` after the last word |
| `S_SEND` | status 0, budget left | `S_SEND` |
| `S_SEND` | status 0, budget spent | `S_END` |
| `S_EXIT_IR` | ack | `S_EXIT_DR` |
| `S_EXIT_DR` | ack | `S_END` |
| `S_END` | always | `S_IDLE` |

Top module: `fxd_download_seq`

## Requirements
- R1: After reset, `done`, `err`, `scan_req` and `src_pop` are 0 and `err_code` is 0.
- R2: A run begins with an IR scan of length 5 carrying the address-register code 0x08, followed by a 32-bit DR scan shifting in zeros. The address is read from `scan_tdo[31:0]`.
- R3: If the entry address is not 0xFF200000, the run ends with `err`=1 and `err_code`=1. No further scans are made and no word is popped.
- R4: For a count above zero, the fast-transfer code 0x0E is loaded by one IR scan of length 5. This happens once, before the first word scan.
- R5: Each word scan has length 33. `scan_tdi[0]` is the request bit and is always 0, and `scan_tdi[32:1]` holds the word.
- R6: A word scan that returns `scan_tdo[0]`=1 pops the source exactly once. The sequencer then moves to the next word.
- R7: A word scan that returns `scan_tdo[0]`=0 does not pop. The identical word is scanned again.
- R8: If `retry_limit` consecutive scans of one word all return 0, the run stops. It ends with `err`=1, `err_code`=2, and `fail_index` set to the zero-based index of that word. A limit of 0 acts as 1.
- R9: After the last word, an IR address scan and a 32-bit DR scan are made. If the returned address is not 0xFF200200, the run ends with `err`=1 and `err_code`=3. Otherwise `err` stays 0.
- R10: `done` is high for exactly one cycle at the end of every run. `err` holds until the next accepted `start`, and that `start` clears it. A `start` during a run is ignored.
- R11: With a word count of 0, the entry check is followed directly by the exit check. No fast-transfer IR scan and no word scan is made.
- R12: `scan_req` stays high, with `scan_ir`, `scan_len` and `scan_tdi` unchanged, until the cycle in which `scan_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| word_count | input | 16 | Number of words in the run, latched at start |
| retry_limit | input | 8 | Maximum scan attempts per word, latched at start |
| src_valid | input | 1 | The source has a word available |
| src_data | input | 32 | Head word of the source |
| src_pop | output | 1 | Removes the head word after it has been accepted |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky error flag |
| err_code | output | 2 | 0 none, 1 entry address, 2 retry timeout, 3 exit address |
| fail_index | output | 16 | Index of the word that timed out |
| scan_req | output | 1 | A scan request is pending |
| scan_ir | output | 1 | 1 for an IR scan, 0 for a DR scan |
| scan_len | output | 6 | Scan length in bits |
| scan_tdi | output | 33 | Bits to shift in, bit 0 first |
| scan_ack | input | 1 | The scan engine has completed the pending scan |
| scan_tdo | input | 33 | Bits shifted out, valid while `scan_ack` is high |

## Verification
The hardest situation to reach from the ports is a word that is refused several times and then accepted, or never accepted. The rest of the run must stay intact around it. The bench's scan-engine model takes a scripted status bit for every scan. A chosen word can therefore be refused a set number of times and the retries compared bit for bit against the same word. Runs with the refusal count both below and at the retry limit cover recovery and timeout. A limit of zero is also covered.

// File: rtl/fxd_pkg.sv
package fxd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENTRY_IR,
        S_ENTRY_DR,
        S_FAST_IR,
        S_WAIT_WORD,
        S_SEND,
        S_EXIT_IR,
        S_EXIT_DR,
        S_END
    } fxd_state_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_IR_ADDR,
        K_IR_FAST,
        K_DR_ADDR,
        K_DR_WORD
    } fxd_kind_t;

    typedef enum logic [1:0] {
        E_NONE    = 2'd0,
        E_ENTRY   = 2'd1,
        E_TIMEOUT = 2'd2,
        E_EXIT    = 2'd3
    } fxd_err_t;

endpackage

// File: rtl/fxd_scan_fmt.sv
module fxd_scan_fmt
    import fxd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IR_W = 5,
    parameter int LEN_W = 6,
    parameter logic [IR_W-1:0] IR_ADDR_CODE = 5'h08,
    parameter logic [IR_W-1:0] IR_FAST_CODE = 5'h0E
) (
    input  fxd_kind_t kind,
    input  logic [DATA_W-1:0] word,
    output logic scan_req,
    output logic scan_ir,
    output logic [LEN_W-1:0] scan_len,
    output logic [DATA_W:0] scan_tdi
);
    localparam int SCAN_W = DATA_W + 1;

    always_comb begin
        scan_req = 1'b1;
        scan_ir  = 1'b0;
        scan_len = '0;
        scan_tdi = '0;
        unique case (kind)
            K_IR_ADDR: begin
                scan_ir  = 1'b1;
                scan_len = LEN_W'(IR_W);
                scan_tdi = {{(SCAN_W-IR_W){1'b0}}, IR_ADDR_CODE};
            end
            K_IR_FAST: begin
                scan_ir  = 1'b1;
                scan_len = LEN_W'(IR_W);
                scan_tdi = {{(SCAN_W-IR_W){1'b0}}, IR_FAST_CODE};
            end
            K_DR_ADDR: begin
                scan_len = LEN_W'(DATA_W);
            end
            K_DR_WORD: begin
                scan_len = LEN_W'(SCAN_W);
                scan_tdi = {word, 1'b0};
            end
            default: scan_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/fxd_counters.sv
module fxd_counters #(
    parameter int CNT_W = 16,
    parameter int ATT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit,
    input  logic miss,
    output logic [CNT_W-1:0] word_idx,
    output logic [ATT_W-1:0] attempts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx <= '0;
            attempts <= '0;
        end else if (clr) begin
            word_idx <= '0;
            attempts <= '0;
        end else if (hit) begin
            word_idx <= word_idx + 1'b1;
            attempts <= '0;
        end else if (miss && attempts != '1) begin
            attempts <= attempts + 1'b1;
        end
    end
endmodule

// File: rtl/fxd_download_seq.sv
module fxd_download_seq
    import fxd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W = 16,
    parameter int ATT_W = 8,
    parameter int IR_W = 5,
    parameter int LEN_W = 6,
    parameter logic [IR_W-1:0] IR_ADDR_CODE = 5'h08,
    parameter logic [IR_W-1:0] IR_FAST_CODE = 5'h0E,
    parameter logic [DATA_W-1:0] ENTRY_ADDR = 32'hFF20_0000,
    parameter logic [DATA_W-1:0] EXIT_ADDR = 32'hFF20_0200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic [CNT_W-1:0] word_count,
    input  logic [ATT_W-1:0] retry_limit,
    input  logic src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic src_pop,
    output logic done,
    output logic err,
    output logic [1:0] err_code,
    output logic [CNT_W-1:0] fail_index,
    output logic scan_req,
    output logic scan_ir,
    output logic [LEN_W-1:0] scan_len,
    output logic [DATA_W:0] scan_tdi,
    input  logic scan_ack,
    input  logic [DATA_W:0] scan_tdo
);
    localparam int ATT_X = ATT_W + 1;

    fxd_state_t state, nstate;
    fxd_kind_t kind;
    logic [CNT_W-1:0] cnt_q;
    logic [ATT_W-1:0] lim_q;
    logic [DATA_W-1:0] word_q;
    logic [CNT_W-1:0] word_idx;
    logic [ATT_W-1:0] attempts;
    logic [ATT_X-1:0] eff_lim;
    logic [DATA_W-1:0] addr_in;
    logic stat_in, tdo_msb_unused;
    logic hit, miss, timeout, last, clr, entry_bad, exit_bad;

    assign addr_in = scan_tdo[DATA_W-1:0];
    assign stat_in = scan_tdo[0];
    assign tdo_msb_unused = scan_tdo[DATA_W];

    assign clr = (state == S_IDLE) && start;
    assign hit = (state == S_SEND) && scan_ack && stat_in;
    assign miss = (state == S_SEND) && scan_ack && !stat_in;
    assign eff_lim = (lim_q == '0) ? ATT_X'(1) : {1'b0, lim_q};
    assign timeout = ({1'b0, attempts} + ATT_X'(1)) >= eff_lim;
    assign last = (word_idx == cnt_q - 1'b1);
    assign entry_bad = (addr_in != ENTRY_ADDR);
    assign exit_bad = (addr_in != EXIT_ADDR);

    fxd_counters #(.CNT_W(CNT_W), .ATT_W(ATT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit), .miss(miss),
        .word_idx(word_idx), .attempts(attempts)
    );

    fxd_scan_fmt #(
        .DATA_W(DATA_W), .IR_W(IR_W), .LEN_W(LEN_W),
        .IR_ADDR_CODE(IR_ADDR_CODE), .IR_FAST_CODE(IR_FAST_CODE)
    ) u_fmt (
        .kind(kind), .word(word_q), .scan_req(scan_req), .scan_ir(scan_ir),
        .scan_len(scan_len), .scan_tdi(scan_tdi)
    );

    always_comb begin
        unique case (state)
            S_ENTRY_IR, S_EXIT_IR: kind = K_IR_ADDR;
            S_ENTRY_DR, S_EXIT_DR: kind = K_DR_ADDR;
            S_FAST_IR:             kind = K_IR_FAST;
            S_SEND:                kind = K_DR_WORD;
            default:               kind = K_NONE;
        endcase
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:      if (start) nstate = S_ENTRY_IR;
            S_ENTRY_IR:  if (scan_ack) nstate = S_ENTRY_DR;
            S_ENTRY_DR: begin
                if (scan_ack) begin
                    if (entry_bad)        nstate = S_END;
                    else if (cnt_q == '0) nstate = S_EXIT_IR;
                    else                  nstate = S_FAST_IR;
                end
            end
            S_FAST_IR:   if (scan_ack) nstate = S_WAIT_WORD;
            S_WAIT_WORD: if (src_valid) nstate = S_SEND;
            S_SEND: begin
                if (hit)                  nstate = last ? S_EXIT_IR : S_WAIT_WORD;
                else if (miss && timeout) nstate = S_END;
            end
            S_EXIT_IR:   if (scan_ack) nstate = S_EXIT_DR;
            S_EXIT_DR:   if (scan_ack) nstate = S_END;
            S_END:       nstate = S_IDLE;
            default:     nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err <= 1'b0;
            err_code <= E_NONE;
            fail_index <= '0;
            cnt_q <= '0;
            lim_q <= '0;
            word_q <= '0;
        end else begin
            if (clr) begin
                err <= 1'b0;
                err_code <= E_NONE;
                fail_index <= '0;
                cnt_q <= word_count;
                lim_q <= retry_limit;
            end
            if (state == S_WAIT_WORD && src_valid) word_q <= src_data;
            if (state == S_ENTRY_DR && scan_ack && entry_bad) begin
                err <= 1'b1;
                err_code <= E_ENTRY;
            end
            if (miss && timeout) begin
                err <= 1'b1;
                err_code <= E_TIMEOUT;
                fail_index <= word_idx;
            end
            if (state == S_EXIT_DR && scan_ack && exit_bad) begin
                err <= 1'b1;
                err_code <= E_EXIT;
            end
        end
    end

    assign done = (state == S_END);
    assign src_pop = hit;
endmodule

// File: rtl/fxd_download_chk.sv
module fxd_download_chk #(
    parameter int DATA_W = 32,
    parameter int LEN_W = 6
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic done,
    input logic err,
    input logic src_pop,
    input logic scan_req,
    input logic scan_ir,
    input logic [LEN_W-1:0] scan_len,
    input logic [DATA_W:0] scan_tdi,
    input logic scan_ack,
    input logic tdo_stat
);
    localparam logic [LEN_W-1:0] WORD_LEN = LEN_W'(DATA_W + 1);

    a_r6_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> (scan_ack && tdo_stat && !scan_ir && scan_len == WORD_LEN));

    a_r5_request_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && !scan_ir && scan_len == WORD_LEN) |-> !scan_tdi[0]);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && !scan_ack) |=>
            (scan_req && $stable(scan_ir) && $stable(scan_len) && $stable(scan_tdi)));
endmodule

bind fxd_download_seq fxd_download_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .src_pop(src_pop), .scan_req(scan_req), .scan_ir(scan_ir),
    .scan_len(scan_len), .scan_tdi(scan_tdi), .scan_ack(scan_ack),
    .tdo_stat(scan_tdo[0])
);

// File: tb/fxd_download_seq_bench.sv
module fxd_download_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] word_count = '0;
    logic [7:0] retry_limit = '0;
    logic src_valid, src_pop, done, err;
    logic [31:0] src_data;
    logic [1:0] err_code;
    logic [15:0] fail_index;
    logic scan_req, scan_ir, scan_ack;
    logic [5:0] scan_len;
    logic [32:0] scan_tdi, scan_tdo;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int n_words = 0;
    int widx = 0;
    int scan_no = 0;
    logic [31:0] words [0:7];

    typedef struct packed {
        logic ir;
        logic [5:0] len;
        logic [32:0] tdi;
    } scan_t;
    scan_t exp_q[$];
    logic [32:0] resp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    fxd_download_seq u_fxd_download_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
        .retry_limit(retry_limit), .src_valid(src_valid), .src_data(src_data),
        .src_pop(src_pop), .done(done), .err(err), .err_code(err_code),
        .fail_index(fail_index), .scan_req(scan_req), .scan_ir(scan_ir),
        .scan_len(scan_len), .scan_tdi(scan_tdi), .scan_ack(scan_ack),
        .scan_tdo(scan_tdo)
    );

    assign src_valid = (widx < n_words);
    assign src_data = (widx < 8) ? words[widx] : 32'h0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (src_pop) widx <= widx + 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scan-engine model with scoreboard monitor
    initial begin
        scan_ack = 1'b0;
        scan_tdo = '0;
        forever begin
            @(negedge clk);
            if (scan_ack) begin
                scan_ack = 1'b0;
            end else if (scan_req) begin
                scan_t got, exp;
                string tg;
                got = '{ir: scan_ir, len: scan_len, tdi: scan_tdi};
                if (exp_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R3 unexpected scan actual=%0h expected=none", got);
                    scan_tdo = '0;
                end else begin
                    exp = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(tg, 64'(got), 64'(exp));
                    scan_tdo = resp_q.pop_front();
                end
                for (int d = 0; d < scan_no % 3; d++) begin
                    @(negedge clk);
                    check("R12", {scan_req, scan_ir, scan_len, scan_tdi}, {1'b1, got});
                end
                scan_no++;
                scan_ack = 1'b1;
            end
        end
    end

    task automatic push(input logic ir, input logic [5:0] len, input logic [32:0] tdi,
                        input logic [32:0] resp, input string tg);
        exp_q.push_back('{ir: ir, len: len, tdi: tdi});
        resp_q.push_back(resp);
        tag_q.push_back(tg);
    endtask

    task automatic run(input string name, input int n, input int lim,
                       input logic [31:0] entry, input logic [31:0] exit_a,
                       input int fw, input int fc);
        int eff, exp_code, exp_idx, exp_pops, guard;
        bit stop;
        eff = (lim == 0) ? 1 : lim;
        exp_code = 0; exp_idx = 0; exp_pops = 0; stop = 0;
        for (int i = 0; i < 8; i++) words[i] = 32'hC3A5_0000 + 32'(i * 32'h0101_0111) + 32'(n);
        widx = 0;
        n_words = n;
        push(1'b1, 6'd5, 33'h08, 33'h0, "R2");
        push(1'b0, 6'd32, 33'h0, {1'b0, entry}, "R2");
        if (entry != 32'hFF20_0000) begin
            exp_code = 1; stop = 1;
        end else begin
            if (n > 0) push(1'b1, 6'd5, 33'h0E, 33'h0, "R4");
            for (int i = 0; i < n && !stop; i++) begin
                int nf;
                nf = (i == fw) ? fc : 0;
                for (int k = 0; k < nf && !stop; k++) begin
                    push(1'b0, 6'd33, {words[i], 1'b0}, 33'h0, "R7");
                    if (k + 1 >= eff) begin
                        stop = 1; exp_code = 2; exp_idx = i;
                    end
                end
                if (!stop) begin
                    push(1'b0, 6'd33, {words[i], 1'b0}, 33'h1, "R5");
                    exp_pops++;
                end
            end
            if (!stop) begin
                push(1'b1, 6'd5, 33'h08, 33'h0, n == 0 ? "R11" : "R9");
                push(1'b0, 6'd32, 33'h0, {1'b0, exit_a}, "R9");
                if (exit_a != 32'hFF20_0200) exp_code = 3;
            end
        end
        @(negedge clk);
        start = 1'b1; word_count = 16'(n); retry_limit = 8'(lim);
        @(negedge clk);
        start = 1'b0;
        check("R10 err cleared by start", 64'(err), 64'd0);
        @(negedge clk);
        start = 1'b1;  // ignored while busy
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        $display("[TB] run %s", name);
        check("R10 done reached", 64'(done), 64'd1);
        check(exp_code == 1 ? "R3" : exp_code == 2 ? "R8" : "R9", 64'(err_code), 64'(exp_code));
        check("R10 err flag", 64'(err), 64'(exp_code != 0));
        if (exp_code == 2) check("R8 fail_index", 64'(fail_index), 64'(exp_idx));
        check("R6 pops", 64'(widx), 64'(exp_pops));
        @(negedge clk);
        check("R10 done pulse", 64'(done), 64'd0);
        check("R3 scoreboard drained", 64'(exp_q.size()), 64'd0);
        repeat (4) @(negedge clk);
        check("R10 err sticky", 64'(err), 64'(exp_code != 0));
        check("R1 no request when idle", 64'(scan_req), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done", 64'(done), 64'd0);
        check("R1 err", 64'(err), 64'd0);
        check("R1 scan_req", 64'(scan_req), 64'd0);
        check("R1 err_code", 64'(err_code), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 src_pop", 64'(src_pop), 64'd0);
        run("clean",       4, 5, 32'hFF20_0000, 32'hFF20_0200, -1, 0);
        run("retry_ok",    5, 5, 32'hFF20_0000, 32'hFF20_0200,  2, 3);
        run("timeout",     4, 4, 32'hFF20_0000, 32'hFF20_0200,  1, 4);
        run("bad_entry",   3, 5, 32'hFF20_0004, 32'hFF20_0200, -1, 0);
        run("bad_exit",    2, 5, 32'hFF20_0000, 32'hFF20_0004,  0, 1);
        run("zero_count",  0, 5, 32'hFF20_0000, 32'hFF20_0200, -1, 0);
        run("limit_zero",  3, 0, 32'hFF20_0000, 32'hFF20_0200,  0, 1);
        run("last_retry",  3, 3, 32'hFF20_0000, 32'hFF20_0200,  2, 2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule